// File: doc/BRIEF.md
# Two-Harmonic Digital Lock-In Demodulator

This block recovers the first and second harmonic content of a modulated signal for one acquisition channel. A stream of signed 14-bit samples is multiplied by sine and cosine references that are synthesised locally. The references run at a programmed fundamental frequency and at twice that frequency. Each of the four products is summed over a programmable number of accepted samples. When the window closes, the four sums are presented together with a one-cycle pulse and the sums restart from zero. The window length therefore sets the lock-in time constant and also decimates the output.

The reference comes from a numerically controlled oscillator. Its 32-bit phase register advances by a tuning word on every valid sample, so the reference stays locked to the sample stream. The second-harmonic phase is derived from the same register by doubling, which keeps the two harmonics coherent. An external sequencer controls the block through three signals. The first is an acquire-enable that travels with each sample. The second is a window-abort strobe that discards a partial window. The third is a phase-clear strobe that restarts the reference at phase zero.

Top module: `lockin_demod`

## Requirements
- R1: During and directly after the synchronous active-high reset, `res_valid` is 0 and all four result outputs read 0.
- R2: The phase register advances by `ftw` (modulo 2^32) once for each cycle in which `smp_valid` is 1, and holds its value in cycles in which `smp_valid` is 0. A sample uses the phase value from before its own advance.
- R3: A cycle with `phase_clr` at 1 sets the phase register to 0, so the next valid sample is demodulated at reference phase 0.
- R4: Let A = 8191 and N = 1024. Let k be bits [31:22] of (phase + `ofs_i`). The in-phase reference is round(A·sin(2π(k+0.5)/N)). The quadrature reference uses bits [31:22] of (phase + `ofs_q`) and round(A·cos(2π(k+0.5)/N)).
- R5: The second-harmonic references use the same formulas and offsets as R4, applied to (2·phase) mod 2^32.
- R6: Samples with both `smp_valid` and `acq_en` at 1 are accepted. Each accepted sample adds sample·reference to the 1f I, 1f Q, 2f I and 2f Q sums. The accepted sample that completes a window of `taps` samples produces the four sums and starts a new empty window. A `taps` value of 0 acts as 1.
- R7: `res_valid` is 1 for exactly one cycle, three clock cycles after the cycle that presents the sample completing a window. The results hold their values until the next window closes.
- R8: A valid sample with `acq_en` at 0 does not enter any sum and does not count toward the window, but it still advances the phase.
- R9: Each running sum saturates at 2147483647 and at -2147483648 after every addition, instead of wrapping.
- R10: A cycle with `acc_clr` at 1 clears all four sums and the window count without producing a result. Samples accepted afterwards start a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed ADC sample |
| acq_en | input | 1 | Sample is accepted into the window when high |
| acc_clr | input | 1 | Abort the partial window and clear the sums |
| phase_clr | input | 1 | Zero the reference phase register |
| ftw | input | 32 | Frequency tuning word added per valid sample |
| ofs_i | input | 32 | Phase offset of the in-phase references |
| ofs_q | input | 32 | Phase offset of the quadrature references |
| taps | input | 16 | Accepted samples per integration window |
| res_valid | output | 1 | One-cycle pulse with a completed window |
| res_1i | output | 32 | Fundamental in-phase sum, signed |
| res_1q | output | 32 | Fundamental quadrature sum, signed |
| res_2i | output | 32 | Second-harmonic in-phase sum, signed |
| res_2q | output | 32 | Second-harmonic quadrature sum, signed |

## Verification
Some properties are checked by assertions on every cycle:
- the phase register steps by the tuning word, holds when no sample arrives, and reads zero after a clear;
- each sum is cleared after a dump;
- a sum never moves against the sign of the product added to it, which is the saturation rule;
- every result pulse follows an accepted sample that was not aborted.

The numeric content of the results can only be shown by the bench scenarios. This covers the reference values from the folded table, the second-harmonic coherence, phase offsets, gaps in the sample stream, gated samples, window aborts, window lengths of 0 and 1, and sums driven into both saturation limits. The bench checks all of these against an arithmetic model, including the cycle in which each result appears.

// File: rtl/lockin_pkg.sv
`timescale 1ns/1ps
package lockin_pkg;
  localparam int NUM_REF = 4;
  typedef enum logic [1:0] {REF_1I = 2'd0, REF_1Q = 2'd1, REF_2I = 2'd2, REF_2Q = 2'd3} ref_sel_e;
endpackage

// File: rtl/lockin_nco.sv
`timescale 1ns/1ps
module lockin_nco
  import lockin_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int LUT_W   = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             step,
  input  logic                             clr,
  input  logic [PHASE_W-1:0]               ftw,
  input  logic [PHASE_W-1:0]               ofs_i,
  input  logic [PHASE_W-1:0]               ofs_q,
  output logic [NUM_REF-1:0][LUT_W-1:0]    idx
);
  localparam logic [LUT_W-1:0] QUARTER = LUT_W'(1) << (LUT_W - 2);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phase2;
  logic [PHASE_W-1:0] th_1i, th_1q, th_2i, th_2q;

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (step)  phase <= phase + ftw;
  end

  // second harmonic derived from the same register keeps both coherent
  assign phase2 = {phase[PHASE_W-2:0], 1'b0};
  assign th_1i  = phase  + ofs_i;
  assign th_1q  = phase  + ofs_q;
  assign th_2i  = phase2 + ofs_i;
  assign th_2q  = phase2 + ofs_q;

  always_comb begin
    idx[REF_1I] = th_1i[PHASE_W-1 -: LUT_W];
    idx[REF_1Q] = th_1q[PHASE_W-1 -: LUT_W] + QUARTER;
    idx[REF_2I] = th_2i[PHASE_W-1 -: LUT_W];
    idx[REF_2Q] = th_2q[PHASE_W-1 -: LUT_W] + QUARTER;
  end

  assert_phase_zero_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase == '0));
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> (phase == $past(phase) + $past(ftw)));
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(phase));
endmodule

// File: rtl/lockin_sine_rom.sv
`timescale 1ns/1ps
module lockin_sine_rom #(
  parameter int AMP_W = 14,
  parameter int LUT_W = 10
) (
  input  logic                    clk,
  input  logic [LUT_W-1:0]        idx,
  output logic signed [AMP_W-1:0] val
);
  localparam int  QDEPTH = 1 << (LUT_W - 2);
  localparam int  MAG_W  = AMP_W - 1;
  localparam real FULL   = real'(1 << LUT_W);
  localparam real PI     = 3.14159265358979323846;

  logic [MAG_W-1:0] qtab [QDEPTH];
  logic [LUT_W-3:0] addr;
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;

  // quarter-wave table sampled at half-step points so the folds are exact
  initial begin
    for (int i = 0; i < QDEPTH; i++) begin
      real ang;
      ang = 2.0 * PI * (real'(i) + 0.5) / FULL;
      qtab[i] = MAG_W'($rtoi(real'((1 << MAG_W) - 1) * $sin(ang) + 0.5));
    end
  end

  assign addr = idx[LUT_W-2] ? ~idx[LUT_W-3:0] : idx[LUT_W-3:0];

  always_ff @(posedge clk) begin
    mag_q <= qtab[addr];
    neg_q <= idx[LUT_W-1];
  end

  assign val = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
endmodule

// File: rtl/lockin_mac.sv
`timescale 1ns/1ps
module lockin_mac #(
  parameter int PROD_W = 28,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     add,
  input  logic                     last,
  input  logic signed [PROD_W-1:0] prod,
  output logic signed [ACC_W-1:0]  res
);
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W-1:0] sat;

  assign sum = $signed({acc[ACC_W-1], acc}) +
               $signed({{(ACC_W + 1 - PROD_W){prod[PROD_W-1]}}, prod});

  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1]) sat = sum[ACC_W] ? MINV : MAXV;
    else                            sat = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (add)    acc <= last ? '0 : sat;
  end

  always_ff @(posedge clk) begin
    if (rst)                    res <= '0;
    else if (add && last && !clr) res <= sat;
  end

  assert_dump_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (add && last) |=> (acc == '0));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (add && !last && !clr && !prod[PROD_W-1]) |=> (acc >= $past(acc)));
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (add && !last && !clr && prod[PROD_W-1]) |=> (acc <= $past(acc)));
  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0));
endmodule

// File: rtl/lockin_demod.sv
`timescale 1ns/1ps
module lockin_demod
  import lockin_pkg::*;
#(
  parameter int SMP_W   = 14,
  parameter int PHASE_W = 32,
  parameter int LUT_W   = 10,
  parameter int TAP_W   = 16,
  parameter int ACC_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_valid,
  input  logic signed [SMP_W-1:0]   smp_data,
  input  logic                      acq_en,
  input  logic                      acc_clr,
  input  logic                      phase_clr,
  input  logic [PHASE_W-1:0]        ftw,
  input  logic [PHASE_W-1:0]        ofs_i,
  input  logic [PHASE_W-1:0]        ofs_q,
  input  logic [TAP_W-1:0]          taps,
  output logic                      res_valid,
  output logic signed [ACC_W-1:0]   res_1i,
  output logic signed [ACC_W-1:0]   res_1q,
  output logic signed [ACC_W-1:0]   res_2i,
  output logic signed [ACC_W-1:0]   res_2q
);
  localparam int PROD_W = 2 * SMP_W;

  logic [NUM_REF-1:0][LUT_W-1:0] idx;
  logic signed [SMP_W-1:0]       ref_v [NUM_REF];
  logic signed [PROD_W-1:0]      prod  [NUM_REF];
  logic signed [ACC_W-1:0]       res   [NUM_REF];

  // stage A: table read, sample aligned with it
  logic                    a_valid, a_en;
  logic signed [SMP_W-1:0] a_data;
  // stage B: products
  logic                    b_valid, b_en;

  logic [TAP_W-1:0] cnt;
  logic [TAP_W-1:0] taps_eff;
  logic             last, fire;

  lockin_nco #(.PHASE_W(PHASE_W), .LUT_W(LUT_W)) u_nco (
    .clk(clk), .rst(rst), .step(smp_valid), .clr(phase_clr),
    .ftw(ftw), .ofs_i(ofs_i), .ofs_q(ofs_q), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      a_en    <= 1'b0;
      b_valid <= 1'b0;
      b_en    <= 1'b0;
    end else begin
      a_valid <= smp_valid;
      a_en    <= acq_en;
      b_valid <= a_valid;
      b_en    <= a_en;
    end
  end

  always_ff @(posedge clk) a_data <= smp_data;

  assign taps_eff = (taps == '0) ? TAP_W'(1) : taps;
  assign last     = (cnt == taps_eff - TAP_W'(1));
  assign fire     = b_valid && b_en && !acc_clr;

  always_ff @(posedge clk) begin
    if (rst || acc_clr) cnt <= '0;
    else if (fire)      cnt <= last ? '0 : cnt + TAP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= fire && last;
  end

  for (genvar j = 0; j < NUM_REF; j++) begin : g_ref
    lockin_sine_rom #(.AMP_W(SMP_W), .LUT_W(LUT_W)) u_rom (
      .clk(clk), .idx(idx[j]), .val(ref_v[j])
    );

    always_ff @(posedge clk) prod[j] <= a_data * ref_v[j];

    lockin_mac #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst(rst), .clr(acc_clr), .add(fire), .last(last),
      .prod(prod[j]), .res(res[j])
    );
  end

  assign res_1i = res[REF_1I];
  assign res_1q = res[REF_1Q];
  assign res_2i = res[REF_2I];
  assign res_2q = res[REF_2Q];

  assert_pulse_source_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(b_valid && b_en && !acc_clr));
  assert_gated_no_count_R8: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_en && !acc_clr) |=> $stable(cnt));
  assert_window_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && !last) |=> (cnt == $past(cnt) + TAP_W'(1)));
endmodule

// File: tb/test_lockin_demod.sv
`timescale 1ns/1ps
module test_lockin_demod;
  localparam int  LUT_W = 10;
  localparam int  AMP   = 8191;
  localparam real PI    = 3.14159265358979323846;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_valid = 1'b0;
  logic signed [13:0] smp_data = '0;
  logic               acq_en = 1'b0;
  logic               acc_clr = 1'b0;
  logic               phase_clr = 1'b0;
  logic [31:0]        ftw = '0, ofs_i = '0, ofs_q = '0;
  logic [15:0]        taps = 16'd1;
  logic               res_valid;
  logic signed [31:0] res_1i, res_1q, res_2i, res_2q;

  int     checks = 0, errors = 0;
  longint cyc = 0;
  string  cur_tag = "R1";

  longint       acc_m [4];
  int           cnt_m = 0;
  logic [31:0]  ph_m = '0;
  longint       exp_due [$];
  logic [127:0] exp_val [$];
  string        exp_tag [$];

  lockin_demod i_lockin_demod (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .acq_en(acq_en), .acc_clr(acc_clr), .phase_clr(phase_clr),
    .ftw(ftw), .ofs_i(ofs_i), .ofs_q(ofs_q), .taps(taps),
    .res_valid(res_valid), .res_1i(res_1i), .res_1q(res_1q),
    .res_2i(res_2i), .res_2q(res_2q)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int ref_val(logic [31:0] th, bit cosf);
    int k; real x, v;
    k = int'(th >> (32 - LUT_W));
    x = 2.0 * PI * (real'(k) + 0.5) / real'(1 << LUT_W);
    v = real'(AMP) * (cosf ? $cos(x) : $sin(x));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic longint sat(longint x);
    if (x > 64'sd2147483647)  return 64'sd2147483647;
    if (x < -64'sd2147483648) return -64'sd2147483648;
    return x;
  endfunction

  function automatic int pat(int k, int s);
    return ((k * 2917 + s * 131) % 16384) - 8192;
  endfunction

  task automatic smp(bit v, int d, bit en);
    int teff; longint p [4]; logic [31:0] ph2; logic [127:0] pk;
    @(negedge clk);
    smp_valid = v; smp_data = d[13:0]; acq_en = en;
    acc_clr = 1'b0; phase_clr = 1'b0;
    if (v) begin
      if (en) begin
        teff = (taps == 0) ? 1 : int'(taps);
        ph2  = {ph_m[30:0], 1'b0};
        p[0] = longint'(d) * ref_val(ph_m + ofs_i, 1'b0);
        p[1] = longint'(d) * ref_val(ph_m + ofs_q, 1'b1);
        p[2] = longint'(d) * ref_val(ph2 + ofs_i, 1'b0);
        p[3] = longint'(d) * ref_val(ph2 + ofs_q, 1'b1);
        if (cnt_m == teff - 1) begin
          for (int j = 0; j < 4; j++) begin
            pk[j*32 +: 32] = 32'(sat(acc_m[j] + p[j]));
            acc_m[j] = 0;
          end
          cnt_m = 0;
          exp_due.push_back(cyc + 3);
          exp_val.push_back(pk);
          exp_tag.push_back(cur_tag);
        end else begin
          for (int j = 0; j < 4; j++) acc_m[j] = sat(acc_m[j] + p[j]);
          cnt_m++;
        end
      end
      ph_m = ph_m + ftw;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) smp(1'b0, 0, 1'b0);
  endtask

  task automatic clear_phase();
    @(negedge clk);
    smp_valid = 1'b0; acq_en = 1'b0; phase_clr = 1'b1;
    ph_m = '0;
    @(negedge clk);
    phase_clr = 1'b0;
  endtask

  task automatic abort_window();
    idle(4);
    @(negedge clk);
    smp_valid = 1'b0; acq_en = 1'b0; acc_clr = 1'b1;
    for (int j = 0; j < 4; j++) acc_m[j] = 0;
    cnt_m = 0;
    @(negedge clk);
    acc_clr = 1'b0;
  endtask

  task automatic run(int n, int s, bit gaps);
    for (int k = 0; k < n; k++) begin
      if (gaps && (k % 3 == 1)) smp(1'b0, pat(k, s), 1'b1);
      smp(1'b1, pat(k, s), 1'b1);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (exp_due.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected result at cycle %0d, expected none", cyc);
        end else begin
          longint due; logic [127:0] e; string t;
          due = exp_due.pop_front(); e = exp_val.pop_front(); t = exp_tag.pop_front();
          chk("R7 result cycle", cyc, due);
          chk({t, " 1f I"}, longint'(res_1i), longint'($signed(e[31:0])));
          chk({t, " 1f Q"}, longint'(res_1q), longint'($signed(e[63:32])));
          chk({t, " 2f I"}, longint'(res_2i), longint'($signed(e[95:64])));
          chk({t, " 2f Q"}, longint'(res_2q), longint'($signed(e[127:96])));
        end
      end else if (exp_due.size() > 0 && exp_due[0] <= cyc) begin
        checks++; errors++;
        $display("FAIL R7: no result at cycle %0d, expected one at cycle %0d", cyc, exp_due[0]);
        void'(exp_due.pop_front()); void'(exp_val.pop_front()); void'(exp_tag.pop_front());
      end
    end
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL R7: watchdog expired at cycle %0d, expected end before cycle 100000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 4; j++) acc_m[j] = 0;
    repeat (5) @(negedge clk);
    chk("R1 valid in reset", longint'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", longint'(res_valid), 0);
    chk("R1 1f I", longint'(res_1i), 0);
    chk("R1 1f Q", longint'(res_1q), 0);
    chk("R1 2f I", longint'(res_2i), 0);
    chk("R1 2f Q", longint'(res_2q), 0);

    cur_tag = "R6"; taps = 16'd8; ftw = 32'd214748365;
    run(24, 1, 1'b0);
    idle(6);

    cur_tag = "R2"; taps = 16'd10; ftw = 32'hF000_0001;
    run(20, 2, 1'b1);
    idle(6);

    cur_tag = "R4"; taps = 16'd12; ftw = 32'd89478485;
    ofs_i = 32'h3A00_0000; ofs_q = 32'h9123_4567;
    run(24, 3, 1'b0);
    idle(6);

    cur_tag = "R5"; ftw = 32'h0123_4567; ofs_i = 32'hC000_0000; ofs_q = 32'h1111_0000;
    run(12, 4, 1'b0);
    idle(6);

    cur_tag = "R3"; taps = 16'd6; ftw = 32'd300000000; ofs_i = '0; ofs_q = '0;
    for (int k = 0; k < 5; k++) smp(1'b1, pat(k, 5), 1'b0);
    clear_phase();
    run(6, 6, 1'b0);
    idle(6);

    cur_tag = "R8"; taps = 16'd7; ftw = 32'd150000000;
    for (int k = 0; k < 21; k++) smp(1'b1, pat(k, 7), (k % 3) != 2);
    idle(6);

    cur_tag = "R6"; taps = 16'd1;
    run(3, 8, 1'b0);
    idle(5);
    taps = 16'd0;
    run(3, 9, 1'b0);
    idle(6);

    cur_tag = "R9"; taps = 16'd64; ftw = '0;
    ofs_i = 32'h3FC0_0000; ofs_q = 32'h3FC0_0000;
    clear_phase();
    for (int k = 0; k < 64; k++) smp(1'b1, 8191, 1'b1);
    for (int k = 0; k < 64; k++) smp(1'b1, -8192, 1'b1);
    idle(6);

    cur_tag = "R10"; taps = 16'd10; ftw = 32'd123456789; ofs_i = '0; ofs_q = 32'h2000_0000;
    run(5, 10, 1'b0);
    abort_window();
    run(10, 11, 1'b0);
    idle(8);

    checks++;
    if (exp_due.size() != 0) begin
      errors++;
      $display("FAIL R6: %0d results outstanding, expected 0", exp_due.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule